// File: doc/BRIEF.md
# Age-Based Memory Port Arbiter

This block sits in front of a memory controller and decides, in every cycle, which of eight request ports may hand its request over. Ports 0 to 3 carry reads and ports 4 to 7 carry writes. Both kinds go through one common selection with no preference by direction. Each port owns a countdown age counter. The counter is loaded from a programmable 10-bit start value. It counts down while that port waits with a request, and it reloads when the port is granted.

The grant is combinational from the current requests and the registered arbitration state, so a requester sees its grant in the same cycle it presents the request. The registered state is made of the counters, the round-robin pointer, the port served last and the address it was served with. This state advances on the next rising clock edge. Four rules choose the winner, and they are applied in strict order:

1. An exhausted port wins. A port is exhausted when its counter is at zero or its start value is zero.
2. If no port is exhausted, the port served last is granted again when its new request falls in the same page.
3. Otherwise, the port with the smallest upper five counter bits wins.
4. Round robin settles any tie left by rules 1 and 3.

Top module: `age_port_arbiter`

## Requirements
- R1: While rst_n is low, grant is all zeros and grant_valid is 0. Reset loads every counter with its start value, points round robin at port 0 and clears the record of the last served port.
- R2: grant_valid is 1 exactly when at least one req_valid bit is 1. When grant_valid is 1, grant has a single bit set (bit i means port i), and that bit belongs to a requesting port.
- R3: A requesting port whose counter is 0, or whose start value is 0, wins over every port that is not in that state.
- R4: With age_en high, a port that requests and is not granted decrements its counter by one per cycle. The counter stops at 0 and never wraps.
- R5: A granted port's counter holds its start value in the following cycle.
- R6: With age_en low, counters of ungranted ports keep their value.
- R7: When no requesting port is exhausted, the port granted last is granted again if it requests and its address ANDed with page_mask equals its previously granted address ANDed with page_mask.
- R8: A page_mask of zero disables the rule of R7 completely.
- R9: When neither R3 nor R7 decides, the winner is among the requesting ports with the smallest value of counter bits [9:5]. Bits [4:0] play no part in the choice.
- R10: Ties under R9 are broken round robin. The search starts at the port numbered one above the most recent winner (wrapping from 7 to 0) and proceeds upward.
- R11: When several requesting ports are exhausted, the same round-robin search picks among them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 8 | Per-port request present |
| req_addr | input | 256 | Per-port request address, port i at bits [32i+31:32i] |
| start_age | input | 80 | Per-port counter start value, port i at bits [10i+9:10i] |
| page_mask | input | 32 | Mask that selects page bits; zero disables page continuation |
| age_en | input | 1 | Enables counting down of waiting ports |
| grant | output | 8 | One-hot grant, bit i for port i |
| grant_valid | output | 1 | A grant is issued this cycle |

## Verification
The grant depends combinationally on the current requests, so the bench drives inputs on the falling edge and compares grant and grant_valid 1 time unit later, before the next rising edge. Counter, pointer and page state are not visible at the ports. Their effect is checked one rising edge later, through the grant of the following cycle. In the long directed aging sequence, that effect shows up only after the number of waiting edges given by the start value. A cycle-by-cycle model in the bench mirrors the rules during a long pseudo-random sweep and predicts every grant under the same sampling discipline.

// File: rtl/arb_pkg.sv
// Shared helpers for the age-based port arbiter.
// Assumes port indices are small non-negative integers.
package arb_pkg;
    // Index of the port that follows cur, wrapping at n.
    function automatic int unsigned next_port(int unsigned cur, int unsigned n);
        return (cur + 1 >= n) ? 0 : cur + 1;
    endfunction
endpackage

// File: rtl/age_counter.sv
// One port's countdown age counter.
// Loads start on reset or when the port is granted. Counts down by one
// while the port waits ungranted with aging enabled. Stops at zero.
// Assumes start is stable while the port waits.
module age_counter #(
    parameter int AGE_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AGE_W-1:0] start,
    input  logic             pending,
    input  logic             granted,
    input  logic             age_en,
    output logic [AGE_W-1:0] count,
    output logic             expired
);
    // Counter load, countdown and saturation.
    always_ff @(posedge clk) begin
        if (!rst_n || granted)
            count <= start;
        else if (pending && age_en && count != '0)
            count <= count - 1'b1;
    end

    // Top priority when either the count or the programmed start is zero.
    always_comb expired = (count == '0) || (start == '0);
endmodule

// File: rtl/page_match.sv
// Compares the masked page of a new address with a remembered one.
// An all-zero mask reports no match.
module page_match #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] prev,
    input  logic [ADDR_W-1:0] mask,
    output logic              hit
);
    // Match only when the mask selects at least one bit.
    always_comb hit = (mask != '0) && (((addr ^ prev) & mask) == '0);
endmodule

// File: rtl/rr_pick.sv
// Round-robin picker.
// Returns the first set candidate found by scanning upward from ptr,
// wrapping at N. Assumes ptr < N.
module rr_pick #(
    parameter int N     = 8,
    parameter int PTR_W = 3
) (
    input  logic [N-1:0]     cand,
    input  logic [PTR_W-1:0] ptr,
    output logic [N-1:0]     sel,
    output logic [PTR_W-1:0] idx,
    output logic             any
);
    // Circular scan from ptr for the first candidate.
    always_comb begin
        sel = '0;
        idx = '0;
        any = 1'b0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = int'(ptr) + k;
            if (j >= N) j = j - N;
            if (!any && cand[j]) begin
                any    = 1'b1;
                sel[j] = 1'b1;
                idx    = PTR_W'(j);
            end
        end
    end
endmodule

// File: rtl/age_port_arbiter.sv
// Age-based request arbiter for the ports of a memory controller.
// The rules, in priority order:
//   1. exhausted age (counter or start value zero)
//   2. same-page continuation of the port served last
//   3. smallest truncated age
//   4. round robin among ties
// The grant is combinational. The state advances on the rising edge.
// Assumes requesters hold req_addr steady while req_valid is high.
module age_port_arbiter
    import arb_pkg::*;
#(
    parameter int NPORT   = 8,
    parameter int AGE_W   = 10,
    parameter int TRUNC_W = 5,
    parameter int ADDR_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORT-1:0]        req_valid,
    input  logic [NPORT*ADDR_W-1:0] req_addr,
    input  logic [NPORT*AGE_W-1:0]  start_age,
    input  logic [ADDR_W-1:0]       page_mask,
    input  logic                    age_en,
    output logic [NPORT-1:0]        grant,
    output logic                    grant_valid
);
    localparam int PTR_W = (NPORT > 1) ? $clog2(NPORT) : 1;
    localparam int TLO   = AGE_W - TRUNC_W;

    logic [NPORT*AGE_W-1:0] age_q;
    logic [NPORT-1:0]       age_zero;
    logic [ADDR_W-1:0]      addr_a [NPORT];

    logic [PTR_W-1:0]  rr_ptr_q, cur_q, win_idx, rr_idx;
    logic              cur_valid_q;
    logic [ADDR_W-1:0] last_addr_q;

    logic [NPORT-1:0]   zero_set, lowest, cand, rr_sel;
    logic [TRUNC_W-1:0] min_t;
    logic               rr_any, hit_raw, page_hit, use_page;

    genvar gi;
    generate
        for (gi = 0; gi < NPORT; gi++) begin : g_port
            assign addr_a[gi] = req_addr[gi*ADDR_W +: ADDR_W];
            age_counter #(.AGE_W(AGE_W)) u_cnt (
                .clk     (clk),
                .rst_n   (rst_n),
                .start   (start_age[gi*AGE_W +: AGE_W]),
                .pending (req_valid[gi]),
                .granted (grant[gi]),
                .age_en  (age_en),
                .count   (age_q[gi*AGE_W +: AGE_W]),
                .expired (age_zero[gi])
            );
        end
    endgenerate

    // Page continuation test for the port served last.
    page_match #(.ADDR_W(ADDR_W)) u_pm (
        .addr (addr_a[cur_q]),
        .prev (last_addr_q),
        .mask (page_mask),
        .hit  (hit_raw)
    );
    always_comb page_hit = cur_valid_q && req_valid[cur_q] && hit_raw;

    // Smallest truncated age among requesters and the set that holds it.
    always_comb begin
        min_t = '1;
        for (int i = 0; i < NPORT; i++)
            if (req_valid[i] && age_q[i*AGE_W+TLO +: TRUNC_W] < min_t)
                min_t = age_q[i*AGE_W+TLO +: TRUNC_W];
        for (int i = 0; i < NPORT; i++)
            lowest[i] = req_valid[i] && (age_q[i*AGE_W+TLO +: TRUNC_W] == min_t);
    end

    // Candidate set: exhausted ports first, else the lowest-age ports.
    always_comb begin
        zero_set = req_valid & age_zero;
        cand     = (|zero_set) ? zero_set : lowest;
    end

    rr_pick #(.N(NPORT), .PTR_W(PTR_W)) u_rr (
        .cand (cand),
        .ptr  (rr_ptr_q),
        .sel  (rr_sel),
        .idx  (rr_idx),
        .any  (rr_any)
    );

    // Final choice between page continuation and the round-robin pick.
    always_comb begin
        use_page = !(|zero_set) && page_hit;
        if (!rst_n) begin
            grant       = '0;
            win_idx     = '0;
            grant_valid = 1'b0;
        end else if (use_page) begin
            grant       = {{(NPORT-1){1'b0}}, 1'b1} << cur_q;
            win_idx     = cur_q;
            grant_valid = 1'b1;
        end else begin
            grant       = rr_sel;
            win_idx     = rr_idx;
            grant_valid = rr_any;
        end
    end

    // Remember the winner, its address and the next round-robin start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr_q    <= '0;
            cur_q       <= '0;
            cur_valid_q <= 1'b0;
            last_addr_q <= '0;
        end else if (grant_valid) begin
            rr_ptr_q    <= PTR_W'(next_port(int'(win_idx), NPORT));
            cur_q       <= win_idx;
            cur_valid_q <= 1'b1;
            last_addr_q <= addr_a[win_idx];
        end
    end
endmodule

// File: rtl/age_port_arbiter_chk.sv
// Property checker for age_port_arbiter, attached by bind.
// Watches the ports and the internal counter vector.
module age_port_arbiter_chk #(
    parameter int NPORT = 8,
    parameter int AGE_W = 10
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NPORT-1:0]       req_valid,
    input logic [NPORT*AGE_W-1:0] start_age,
    input logic                   age_en,
    input logic [NPORT-1:0]       grant,
    input logic                   grant_valid,
    input logic [NPORT*AGE_W-1:0] age_q
);
    p_quiet_in_reset_r1: assert property (@(posedge clk)
        !rst_n |-> (!grant_valid && grant == '0));

    p_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid == (|req_valid));

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> $countones(grant) == 1);

    p_only_requester_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req_valid) == '0);

    genvar gi;
    generate
        for (gi = 0; gi < NPORT; gi++) begin : g_chk
            p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (req_valid[gi] && age_en && !grant[gi] && age_q[gi*AGE_W +: AGE_W] != '0)
                |=> age_q[gi*AGE_W +: AGE_W] == $past(age_q[gi*AGE_W +: AGE_W]) - 1'b1);

            p_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (age_q[gi*AGE_W +: AGE_W] == '0 && !grant[gi])
                |=> age_q[gi*AGE_W +: AGE_W] == '0);

            p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
                grant[gi] |=> age_q[gi*AGE_W +: AGE_W] == $past(start_age[gi*AGE_W +: AGE_W]));

            p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (!age_en && !grant[gi]) |=> $stable(age_q[gi*AGE_W +: AGE_W]));
        end
    endgenerate
endmodule

bind age_port_arbiter age_port_arbiter_chk #(.NPORT(NPORT), .AGE_W(AGE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .start_age   (start_age),
    .age_en      (age_en),
    .grant       (grant),
    .grant_valid (grant_valid),
    .age_q       (age_q)
);

// File: tb/sim_age_port_arbiter.sv
// Directed cases for each rule, then a long pseudo-random sweep checked
// against a cycle model of the rules.
module sim_age_port_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 8, AW = 10, DW = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NP-1:0]  req_valid = '0;
    logic [NP*DW-1:0] req_addr = '0;
    logic [NP*AW-1:0] start_age = '1;
    logic [DW-1:0]  page_mask = '0;
    logic           age_en = 1'b0;
    logic [NP-1:0]  grant;
    logic           grant_valid;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    age_port_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .start_age(start_age), .page_mask(page_mask), .age_en(age_en),
        .grant(grant), .grant_valid(grant_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD*200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [NP-1:0] exp_g, input logic exp_v);
        checks++;
        if (grant !== exp_g || grant_valid !== exp_v) begin
            failures++;
            $display("FAIL %s: actual grant=%b valid=%b expected grant=%b valid=%b",
                     tag, grant, grant_valid, exp_g, exp_v);
        end
    endtask

    // Sample just after the falling-edge drive, then finish the cycle.
    task automatic cyc(input string tag, input logic [NP-1:0] exp_g);
        #1;
        check(tag, exp_g, exp_g != '0);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_start(input int p, input int v);
        start_age[p*AW +: AW] = AW'(v);
    endtask

    task automatic set_addr(input int p, input logic [DW-1:0] a);
        req_addr[p*DW +: DW] = a;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Cycle model state for the sweep.
    int mc[NP];
    int st[NP];
    int mptr, mcur, win, minv;
    bit mcv;
    logic [DW-1:0] mlast;

    initial begin
        @(negedge clk);
        // R1: no grant while reset is held, even with requests present.
        rst_n = 1'b0;
        req_valid = 8'hFF;
        #1 check("R1 quiet in reset", '0, 1'b0);
        @(posedge clk);
        @(negedge clk);
        req_valid = 8'b0000_0011;
        rst_n = 1'b1;
        cyc("R1 pointer at port 0 after reset", 8'b0000_0001);
        req_valid = '0;
        cyc("R2 no request no grant", '0);

        // R3: programmed zero start wins.
        start_age = '1;
        set_start(4, 0);
        do_reset();
        req_valid = 8'b1001_0001;
        cyc("R3 zero start wins", 8'b0001_0000);

        // R9 / R10: truncated age and round-robin ties.
        start_age = '1;
        set_start(2, 'h03F);
        set_start(6, 'h020);
        age_en = 1'b0;
        do_reset();
        req_valid = 8'b0100_0010;
        cyc("R9 lowest truncated age", 8'b0100_0000);
        req_valid = 8'b0100_0100;
        cyc("R9 low bits ignored, R10 wraps from 7", 8'b0000_0100);
        cyc("R10 pointer after last winner", 8'b0100_0000);

        // R7 / R8: page continuation.
        start_age = '1;
        set_start(0, 'h020);
        page_mask = 32'hFFFF_F000;
        do_reset();
        set_addr(3, 32'h1000);
        set_addr(0, 32'h5000);
        req_valid = 8'b0000_1000;
        cyc("R7 setup", 8'b0000_1000);
        set_addr(3, 32'h1ABC);
        req_valid = 8'b0000_1001;
        cyc("R7 same page regranted", 8'b0000_1000);
        set_addr(3, 32'h2000);
        cyc("R7 page change falls to age", 8'b0000_0001);
        page_mask = '0;
        do_reset();
        set_addr(3, 32'h1000);
        req_valid = 8'b0000_1000;
        cyc("R8 setup", 8'b0000_1000);
        set_addr(3, 32'h1ABC);
        req_valid = 8'b0000_1001;
        cyc("R8 zero mask no continuation", 8'b0000_0001);

        // R4 / R5 / R11: aging to zero against a permanent zero-start port.
        start_age = '1;
        set_start(1, 0);
        set_start(5, 3);
        age_en = 1'b1;
        do_reset();
        req_valid = 8'b0010_0010;
        cyc("R4 wait 1", 8'b0000_0010);
        cyc("R4 wait 2", 8'b0000_0010);
        cyc("R4 wait 3", 8'b0000_0010);
        cyc("R4 R11 aged port wins zero tie", 8'b0010_0000);
        cyc("R5 reloaded after grant", 8'b0000_0010);

        // R6: no aging when disabled.
        age_en = 1'b0;
        do_reset();
        for (int k = 0; k < 5; k++) cyc("R6 counter held", 8'b0000_0010);

        // Sweep against the cycle model.
        for (int i = 0; i < NP; i++) begin
            st[i] = (i*37 + 5) & 'h7F;
            set_start(i, st[i]);
        end
        page_mask = 32'hFFFF_F000;
        age_en = 1'b1;
        req_valid = '0;
        do_reset();
        for (int i = 0; i < NP; i++) mc[i] = st[i];
        mptr = 0; mcv = 1'b0; mlast = '0; mcur = 0;
        begin
            logic [31:0] lfsr;
            lfsr = 32'hACE1_2345;
            for (int c = 0; c < 4000; c++) begin
                logic [NP-1:0] cand, zero, exp_g;
                string tag;
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                req_valid = lfsr[7:0];
                for (int i = 0; i < NP; i++)
                    set_addr(i, {18'd0, lfsr[8 + (i % 4) +: 2], 12'd0} | DW'(i*4));
                if (c % 64 == 0) age_en = ~age_en;
                if (c == 2000) page_mask = '0;
                // Model: R3/R11, then R7/R8, then R9/R10.
                zero = '0;
                for (int i = 0; i < NP; i++)
                    zero[i] = req_valid[i] && (mc[i] == 0 || st[i] == 0);
                win = -1;
                tag = "R2 idle";
                if (zero != '0) begin
                    cand = zero;
                    tag = "R3 R11 sweep zero age";
                end else if (mcv && req_valid[mcur] && page_mask != '0 &&
                             (((req_addr[mcur*DW +: DW] ^ mlast) & page_mask) == '0)) begin
                    cand = '0;
                    win = mcur;
                    tag = "R7 sweep page hit";
                end else begin
                    minv = 99;
                    for (int i = 0; i < NP; i++)
                        if (req_valid[i] && (mc[i] >> 5) < minv) minv = mc[i] >> 5;
                    cand = '0;
                    for (int i = 0; i < NP; i++)
                        cand[i] = req_valid[i] && (mc[i] >> 5) == minv;
                    tag = ($countones(cand) > 1) ? "R10 sweep tie" : "R9 sweep lowest";
                end
                if (win < 0)
                    for (int k = 0; k < NP; k++)
                        if (win < 0 && cand[(mptr + k) % NP]) win = (mptr + k) % NP;
                exp_g = (win >= 0) ? (8'd1 << win) : '0;
                #1;
                check(tag, exp_g, win >= 0);
                @(posedge clk);
                for (int i = 0; i < NP; i++) begin
                    if (i == win) mc[i] = st[i];
                    else if (req_valid[i] && age_en && mc[i] > 0) mc[i] = mc[i] - 1;
                end
                if (win >= 0) begin
                    mcur = win;
                    mcv = 1'b1;
                    mlast = req_addr[win*DW +: DW];
                    mptr = (win + 1) % NP;
                end
                @(negedge clk);
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule